// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Mover

This block sits on the device side of a byte-wide shift register shared with a host. It moves message bytes between the two under the control of three active-low handshake lines. The host drives transfer-in-progress (`tip_n`) and acknowledge (`ack_n`). The device drives request (`req_n`). The host's direction setting (`dir_h2d`) chooses which way the bytes go. When it is 1, the host is shifting out: each byte placed in the shift register is appended to an outbound buffer. When it is 0, each step loads the next byte of a preloaded reply into the shift register, and the host reads it from there.

Bytes do not advance on a shift clock. One byte moves on every sampled change of the pair {`tip_n`, `ack_n`} while `tip_n` is low. When `tip_n` returns high the transfer is over. The block then reports any collected outbound packet with a one-cycle `pkt_valid` pulse and its length, raises the shift-register interrupt, and pulls `req_n` low if reply bytes are still unread. While no transfer is in progress, `req_n` follows `ack_n`. A reply packet is loaded through a valid/ready byte stream. `in_ready` is high only while the handshake is idle, so a packet source is held back for as long as the host has a transfer open. A beat marked `in_last` ends the packet.

Top module: `sr_handshake_xfer`

## Requirements
- R1: After reset the outputs are `req_n`=1, `irq`=0, `pkt_valid`=0 and `sr_q`=0. With `tip_n` high, `in_ready`=1.
- R2: A move happens on each clock edge where `tip_n` is 0 and {`tip_n`,`ack_n`} differs from its value at the previous edge. With `dir_h2d`=1, each move stores `sr_q` at the next outbound index, starting at 0. The stored bytes can be read at `out_rd_data` for address `out_rd_addr`.
- R3: Once DEPTH bytes are stored, further host-to-device moves are discarded and do not set `irq`.
- R4: An end of transfer is a clock edge where `tip_n` is 1 and was 0 at the previous edge. If one or more bytes were stored, `pkt_valid` is high for exactly one cycle with `pkt_len` equal to the stored count, and the next packet starts again at index 0. With nothing stored there is no pulse.
- R5: Every stored or loaded byte, and every end of transfer, sets `irq`. `irq` stays set until `irq_clr`, and a set in the same cycle as `irq_clr` wins.
- R6: With `dir_h2d`=0, each move loads the next unread reply byte into `sr_q`, in the order the bytes were streamed in. A later transfer continues from where an earlier one stopped.
- R7: The move that loads the last reply byte drives `req_n` to 1 on the same edge. Moves made after that leave `sr_q` unchanged.
- R8: At an end of transfer, `req_n` goes to 0 if reply bytes remain unread. Otherwise it is left as it was.
- R9: When `tip_n` is 1 at both the current and the previous edge and `ack_n` changes, `req_n` takes the new `ack_n` level.
- R10: `in_ready` is 1 only when `tip_n` is 1 now and was 1 at the previous edge. A beat transfers when `in_valid` and `in_ready` are both 1. A beat with `in_last` commits the packet, rewinds the reply to its first byte and drives `req_n` to 0. Beats beyond DEPTH are accepted and dropped.
- R11: `sr_wr_en` loads `sr_wr_data` into `sr_q`. A device-to-host move in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tip_n | input | 1 | Transfer in progress from host, active low |
| ack_n | input | 1 | Acknowledge from host, active low |
| req_n | output | 1 | Request to host, active low |
| dir_h2d | input | 1 | 1: host shifts bytes out to device |
| sr_wr_en | input | 1 | Host write strobe for the shift register |
| sr_wr_data | input | 8 | Host write data for the shift register |
| sr_q | output | 8 | Shift register contents |
| irq | output | 1 | Shift-register interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| in_valid | input | 1 | Reply stream beat valid |
| in_ready | output | 1 | Reply stream ready |
| in_data | input | 8 | Reply stream byte |
| in_last | input | 1 | Last beat of a reply packet |
| pkt_valid | output | 1 | One-cycle pulse: outbound packet complete |
| pkt_len | output | $clog2(DEPTH+1) | Outbound packet length |
| out_rd_addr | input | $clog2(DEPTH) | Outbound buffer read address |
| out_rd_data | output | 8 | Outbound buffer byte at that address |

## Verification
A stale outbound index shows up in the very next packet. `pkt_len` comes out wrong at the end-of-transfer pulse, and the read-back bytes appear shifted. A wrong reply read index or size puts the wrong byte in `sr_q` one edge after the offending handshake change, or makes `req_n` release early or late. The sweeps cover every packet length from one byte to two beyond the buffer depth in both directions, so off-by-one errors at the full boundary appear within the packet that crosses it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic move;   // handshake change while transfer open
    logic fin;    // transfer just closed
    logic sync;   // ack changed while idle
  } hs_evt_t;
endpackage

// File: rtl/srx_hs_sense.sv
module srx_hs_sense
  import srx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tip_n,
  input  logic    ack_n,
  output hs_evt_t evt,
  output logic    idle
);
  logic tip_q, ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tip_q <= 1'b1;
      ack_q <= 1'b1;
    end else begin
      tip_q <= tip_n;
      ack_q <= ack_n;
    end
  end

  always_comb begin
    evt.move = !tip_n && ({tip_n, ack_n} != {tip_q, ack_q});
    evt.fin  = tip_n && !tip_q;
    evt.sync = tip_n && tip_q && (ack_n != ack_q);
    idle     = tip_n && tip_q;
  end
endmodule

// File: rtl/srx_out_collect.sv
module srx_out_collect #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          flush,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          accepted,
  output logic          pkt_valid,
  output logic [IW-1:0] pkt_len
);
  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx;

  assign accepted = push && (idx < IW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accepted && idx == IW'(g)) mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      pkt_valid <= flush && (idx != '0);
      if (flush) begin
        pkt_len <= idx;
        idx     <= '0;
      end else if (accepted) begin
        idx <= idx + IW'(1);
      end
    end
  end

  assign rd_data = mem[rd_addr];

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(DEPTH));
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IW'(DEPTH) && !flush) |=> idx == IW'(DEPTH));
  assert_pkt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_len != '0);
  assert_pkt_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);
  assert_flush_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> idx == '0);
endmodule

// File: rtl/srx_in_source.sv
module srx_in_source #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int IW    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       pop,
  output logic [7:0] head,
  output logic       avail,
  output logic       at_last,
  output logic       commit
);
  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] fill, size, rd;
  logic          beat, room;

  assign in_ready = open;
  assign beat     = in_valid && open;
  assign room     = fill < IW'(DEPTH);
  assign commit   = beat && in_last;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (beat && fill == IW'(g)) mem[g] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      size <= '0;
      rd   <= '0;
    end else if (beat) begin
      rd <= '0;
      if (in_last) begin
        size <= room ? fill + IW'(1) : IW'(DEPTH);
        fill <= '0;
      end else begin
        if (fill == '0) size <= '0;
        if (room) fill <= fill + IW'(1);
      end
    end else if (pop && avail) begin
      rd <= rd + IW'(1);
    end
  end

  assign avail   = rd < size;
  assign at_last = (rd + IW'(1)) == size;
  assign head    = (rd < IW'(DEPTH)) ? mem[rd[AW-1:0]] : 8'h00;

  assert_rd_le_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd <= size);
  assert_commit_rewind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (rd == '0 && size != '0));
  assert_no_beat_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !in_ready);
endmodule

// File: rtl/sr_handshake_xfer.sv
module sr_handshake_xfer
  import srx_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tip_n,
  input  logic          ack_n,
  output logic          req_n,
  input  logic          dir_h2d,
  input  logic          sr_wr_en,
  input  logic [7:0]    sr_wr_data,
  output logic [7:0]    sr_q,
  output logic          irq,
  input  logic          irq_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          pkt_valid,
  output logic [IW-1:0] pkt_len,
  input  logic [AW-1:0] out_rd_addr,
  output logic [7:0]    out_rd_data
);
  hs_evt_t    evt;
  logic       idle, push, pop, loaded, stored;
  logic       avail, at_last, commit;
  logic [7:0] head;

  srx_hs_sense u_sense (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n),
    .evt(evt), .idle(idle)
  );

  assign push   = evt.move && dir_h2d;
  assign pop    = evt.move && !dir_h2d;
  assign loaded = pop && avail;

  srx_out_collect #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .din(sr_q), .flush(evt.fin),
    .rd_addr(out_rd_addr), .rd_data(out_rd_data), .accepted(stored),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len)
  );

  srx_in_source #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_in (
    .clk(clk), .rst_n(rst_n), .open(idle), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .pop(pop), .head(head), .avail(avail), .at_last(at_last),
    .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      irq   <= 1'b0;
      req_n <= 1'b1;
    end else begin
      if (loaded)        sr_q <= head;
      else if (sr_wr_en) sr_q <= sr_wr_data;

      if (stored || loaded || evt.fin) irq <= 1'b1;
      else if (irq_clr)                irq <= 1'b0;

      if (loaded && at_last)    req_n <= 1'b1;
      else if (evt.fin && avail) req_n <= 1'b0;
      else if (commit)           req_n <= 1'b0;
      else if (evt.sync)         req_n <= ack_n;
    end
  end

  assert_last_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && at_last) |=> req_n);
  assert_pending_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fin && avail) |=> !req_n);
  assert_sync_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sync && !commit) |=> req_n == $past(ack_n));
  assert_fin_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fin |=> irq);
  assert_load_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> sr_q == $past(head));
  assert_commit_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !req_n);
endmodule

// File: tb/sr_handshake_xfer_tb_top.sv
module sr_handshake_xfer_tb_top;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int IW     = $clog2(DEPTH + 1);
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tip_n = 1'b1, ack_n = 1'b1, dir_h2d = 1'b1;
  logic sr_wr_en = 1'b0, irq_clr = 1'b0;
  logic [7:0] sr_wr_data = '0, in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [AW-1:0] out_rd_addr = '0;
  logic req_n, irq, in_ready, pkt_valid;
  logic [7:0] sr_q, out_rd_data;
  logic [IW-1:0] pkt_len;
  int checks = 0, errors = 0;

  always #(PERIOD / 2) clk = ~clk;

  sr_handshake_xfer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .req_n(req_n),
    .dir_h2d(dir_h2d), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_q(sr_q), .irq(irq), .irq_clr(irq_clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .out_rd_addr(out_rd_addr),
    .out_rd_data(out_rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat_o(input int n, input int i);
    return (n * 37 + i * 11 + 5) & 255;
  endfunction

  function automatic int pat_i(input int n, input int i);
    return ((n * 29) ^ (i * 13) ^ 8'h5A) & 255;
  endfunction

  task automatic end_xfer();
    @(negedge clk); tip_n = 1'b1; ack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_h2d(input int n);
    int m;
    m = (n < DEPTH) ? n : DEPTH;
    dir_h2d = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sr_wr_en = 1'b1; sr_wr_data = 8'(pat_o(n, i)); irq_clr = 1'b1;
      @(negedge clk); sr_wr_en = 1'b0; irq_clr = 1'b0;
      if (i == 0) tip_n = 1'b0; else ack_n = ~ack_n;
      @(negedge clk);
      if (i < DEPTH) check("R5 irq after stored byte", int'(irq), 1);
      else           check("R3 irq after discarded byte", int'(irq), 0);
    end
    @(negedge clk); tip_n = 1'b1; ack_n = 1'b1; irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R4 pkt_valid at end", int'(pkt_valid), 1);
    check("R4 pkt_len", int'(pkt_len), m);
    check("R5 end sets irq over clear", int'(irq), 1);
    @(negedge clk);
    check("R4 pkt_valid one cycle", int'(pkt_valid), 0);
    for (int i = 0; i < m; i++) begin
      out_rd_addr = AW'(i);
      #1;
      check(n > DEPTH ? "R3 kept byte" : "R2 stored byte", int'(out_rd_data), pat_o(n, i));
    end
  endtask

  task automatic load_in(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) check("R10 in_ready when idle", int'(in_ready), 1);
      in_valid = 1'b1; in_data = 8'(pat_i(n, i)); in_last = (i == n - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    check("R10 req_n after commit", int'(req_n), 0);
  endtask

  task automatic read_bytes(input int n, input int first, input int cnt, input int m);
    dir_h2d = 1'b0;
    for (int i = first; i < first + cnt; i++) begin
      @(negedge clk);
      if (tip_n) tip_n = 1'b0; else ack_n = ~ack_n;
      @(negedge clk);
      check("R6 reply byte", int'(sr_q), pat_i(n, i));
      check("R7 req_n during reply", int'(req_n), (i == m - 1) ? 1 : 0);
      check("R10 in_ready busy", int'(in_ready), 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_n", int'(req_n), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 pkt_valid", int'(pkt_valid), 0);
    check("R1 sr_q", int'(sr_q), 0);
    check("R1 in_ready", int'(in_ready), 1);

    sr_wr_en = 1'b1; sr_wr_data = 8'hA5;
    @(negedge clk); sr_wr_en = 1'b0;
    check("R11 sr write", int'(sr_q), 8'hA5);

    ack_n = 1'b0;
    @(negedge clk); check("R9 req follows ack low", int'(req_n), 0);
    ack_n = 1'b1;
    @(negedge clk); check("R9 req follows ack high", int'(req_n), 1);

    // empty transfer: no reply queued, device-to-host
    dir_h2d = 1'b0;
    @(negedge clk); tip_n = 1'b0; irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R6 no byte without reply", int'(sr_q), 8'hA5);
    end_xfer();
    check("R4 no pulse when empty", int'(pkt_valid), 0);
    check("R5 irq at empty end", int'(irq), 1);
    @(negedge clk);
    check("R4 no pulse later", int'(pkt_valid), 0);

    for (int n = 1; n <= DEPTH + 2; n++) run_h2d(n);

    for (int n = 1; n <= DEPTH + 2; n++) begin
      int m;
      m = (n < DEPTH) ? n : DEPTH;
      load_in(n);
      read_bytes(n, 0, m, m);
      @(negedge clk); ack_n = ~ack_n;
      @(negedge clk);
      check("R7 sr_q held after last", int'(sr_q), pat_i(n, m - 1));
      check("R7 req_n stays high", int'(req_n), 1);
      end_xfer();
      check("R8 no pending request", int'(req_n), 1);
    end

    load_in(5);
    read_bytes(5, 0, 2, 5);
    end_xfer();
    check("R8 pending bytes request", int'(req_n), 0);
    @(negedge clk); tip_n = 1'b0; sr_wr_en = 1'b1; sr_wr_data = 8'h3C;
    @(negedge clk); sr_wr_en = 1'b0;
    check("R11 move beats sr write", int'(sr_q), pat_i(5, 2));
    check("R6 resume reply", int'(req_n), 0);
    end_xfer();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule